// File: doc/BRIEF.md
# SDRAM command and refresh controller

This block sits between a single host port and one four-bank, 32-bit synchronous DRAM. The host presents one request at a time with a request/ready handshake: a read/write flag, a flat word address, 32-bit write data and a per-byte write enable. Read data returns a fixed number of cycles later with a one-cycle valid strobe. On the memory side the block drives clock enable, the four active-low command strobes, the bank select, a 12-bit multiplexed address, the byte masks and a shared bidirectional data bus. All of these are registered.

After reset the controller runs the power-up sequence on its own. It programs the mode register for single-beat sequential bursts and the chosen CAS latency. It then serves host accesses while keeping one row open at a time. Every minimum gap between commands is enforced as a clock count set at elaboration. An auto-refresh is slotted in on a fixed interval and takes priority over new host requests. It never cuts into a read whose data is still in flight.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: After reset, clock enable goes high and only NOPs are issued for INIT_WAIT cycles. Then come a precharge with address bit 10 high, two auto-refreshes and one mode register set. `init_done` and `req_ready` stay low until T_MRD cycles after the mode register set, and no request is accepted before then.
- R2: Commands use the encoding {cs_n, ras_n, cas_n, we_n}: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode set 0000. No other encoding with cs_n low is ever driven, and the reset value on the pins is NOP.
- R3: The mode word is A[2:0]=000 (one beat), A3=0 (sequential), A[6:4]=CAS_LAT, with the other address bits and the bank select at 0.
- R4: `req_addr[20:19]` is the bank, `[18:8]` the row and `[7:0]` the column. An activate drives the row on A[10:0] with A11=0. A read or write drives the column on A[7:0] with A[11:8]=0, which means no auto-precharge. It addresses the open bank no earlier than T_RCD cycles after its activate.
- R5: A precharge of the open bank comes at least T_RAS cycles after its activate and at least T_WR cycles after the last write. An activate comes at least T_RP cycles after a precharge and at least T_RC cycles after the previous activate or auto-refresh.
- R6: An auto-refresh is issued only with no row open. It is issued at least T_RP after a precharge and at least T_RC after the previous refresh. Consecutive run-time refreshes are at most REF_INTERVAL plus 30 cycles apart.
- R7: A request to the open bank and row issues no new activate. A request to another row or bank precharges the open bank (A10=0) and then activates the new row.
- R8: A write drives the data on DQ in the write-command cycle. DQM bit i is high when `req_wmask[i]` is 0, and byte i is DQ[8i+7:8i]. Masked bytes keep their old contents.
- R9: Read data is sampled CAS_LAT cycles after the read command. `rd_valid` pulses for one cycle with that word, and only one read is outstanding.
- R10: A refresh that falls due while a read is in flight or a row is open is held and issued later, never dropped. Over a run the number of run-time refreshes is at least the elapsed cycles divided by REF_INTERVAL, minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the memory |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | output | 1 | Power-up sequence finished |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_wmask | input | 4 | Per-byte write enable |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Read data |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | 12 | Multiplexed row/column/mode address |
| mem_dqm | output | 4 | Byte masks |
| mem_dq | inout | 32 | Bidirectional data bus |

## Verification
The bench carries a cycle-accurate memory that reports any command that breaks a minimum gap:
- A controller that counted a timer one short would issue a read inside T_RCD or a precharge inside T_RAS.
- One that forgot the refresh while a row was open would refresh with a bank active.
- One that dropped a refresh coinciding with a read would fall behind the refresh count.

Row hits and misses are driven on purpose so that a wrong open-row policy shows up as extra or missing activates. Partial byte masks are read back, so an inverted DQM sense corrupts the merged word. Requests are held during power-up to catch a controller that answers before the mode register is settled.

// File: rtl/sdr_ctrl_pkg.sv
// Package: command encodings and controller state type shared by the
// SDRAM command controller. Encoding order is {cs_n, ras_n, cas_n, we_n}.
package sdr_ctrl_pkg;

    typedef logic [3:0] sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = 4'b0111;
    localparam sdr_cmd_t CMD_ACT = 4'b0011;
    localparam sdr_cmd_t CMD_RD  = 4'b0101;
    localparam sdr_cmd_t CMD_WR  = 4'b0100;
    localparam sdr_cmd_t CMD_PRE = 4'b0010;
    localparam sdr_cmd_t CMD_REF = 4'b0001;
    localparam sdr_cmd_t CMD_MRS = 4'b0000;

    typedef enum logic [2:0] {
        ST_BOOT,    // load the power-up wait
        ST_PWR,     // power-up NOPs, then precharge all
        ST_IREF,    // two initial auto-refreshes
        ST_IMRS,    // mode register set
        ST_MWAIT,   // wait out the mode-set gap
        ST_IDLE,    // serve host and refresh
        ST_RDWAIT   // read data in flight
    } ctrl_st_e;

endpackage

// File: rtl/sdr_down_ctr.sv
// Module: loadable down-counter used as a minimum-gap timer.
// Assumes: load_val N-1 makes zero rise N cycles after the load cycle.
module sdr_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Purpose: count down to zero, restarting on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
// Module: periodic refresh request generator.
// Raises a sticky 'due' every INTERVAL cycles while 'run' is high and clears
// it on 'ack'. A new tick in the acknowledge cycle wins, so no tick is lost.
module sdr_refresh_timer #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic due
);

    localparam int RW = $clog2(INTERVAL + 1);

    logic [RW-1:0] cnt_q;
    logic          due_q;

    // Purpose: interval countdown and sticky due flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= RW'(INTERVAL - 1);
            due_q <= 1'b0;
        end else begin
            if (ack) begin
                due_q <= 1'b0;
            end
            if (cnt_q == '0) begin
                cnt_q <= RW'(INTERVAL - 1);
                due_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign due = due_q;

    // R10: a pending refresh is held until it is acknowledged.
    a_r10_due_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (due_q && !ack && run) |=> due_q);

endmodule

// File: rtl/sdr_cmd_ctrl.sv
// Module: single-port SDRAM command and refresh controller (top).
// Runs power-up init, keeps one row open, serves single-beat reads/writes and
// inserts periodic auto-refresh. All memory-side outputs are registered.
// Assumes: T_RC >= T_RAS, T_RCD, T_RP, T_MRD, T_WR; CAS_LAT is 2 or 3;
// req_ready depends combinationally on req_valid.
module sdr_cmd_ctrl
    import sdr_ctrl_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 11,
    parameter int COL_W        = 8,
    parameter int MA_W         = 12,
    parameter int DQ_W         = 32,
    parameter int CAS_LAT      = 3,
    parameter int INIT_WAIT    = 100,
    parameter int REF_INTERVAL = 1950,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RAS        = 7,
    parameter int T_RC         = 10,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic                           init_done,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0]  req_addr,
    input  logic [DQ_W-1:0]                req_wdata,
    input  logic [DQ_W/8-1:0]              req_wmask,
    output logic                           rd_valid,
    output logic [DQ_W-1:0]                rd_data,
    output logic                           mem_cke,
    output logic                           mem_cs_n,
    output logic                           mem_ras_n,
    output logic                           mem_cas_n,
    output logic                           mem_we_n,
    output logic [BANK_W-1:0]              mem_ba,
    output logic [MA_W-1:0]                mem_addr,
    output logic [DQ_W/8-1:0]              mem_dqm,
    inout  wire  [DQ_W-1:0]                mem_dq
);

    localparam int BE_W    = DQ_W / 8;
    localparam int AP_BIT  = 10;
    localparam int BIGGEST = (INIT_WAIT > T_RC) ? INIT_WAIT : T_RC;
    localparam int CW      = $clog2(BIGGEST + 2);
    localparam logic [MA_W-1:0] MODE_WORD = MA_W'({3'(CAS_LAT), 4'b0000});

    // Request field split.
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    assign req_bank = req_addr[COL_W+ROW_W +: BANK_W];
    assign req_row  = req_addr[COL_W +: ROW_W];
    assign req_col  = req_addr[0 +: COL_W];

    // State and open-row tracking.
    ctrl_st_e          st_q, st_d;
    logic              iref_q, iref_d;
    logic              row_open_q, row_open_d;
    logic [BANK_W-1:0] open_bank_q, open_bank_d;
    logic [ROW_W-1:0]  open_row_q, open_row_d;

    // Registered pin values.
    sdr_cmd_t          cmd_q, cmd_d;
    logic              cke_q;
    logic [BANK_W-1:0] ba_q, ba_d;
    logic [MA_W-1:0]   ma_q, ma_d;
    logic [BE_W-1:0]   dqm_q, dqm_d;
    logic              dq_oe_q, dq_oe_d;
    logic [DQ_W-1:0]   dq_out_q, dq_out_d;
    logic [CAS_LAT:0]  rd_pipe_q;
    logic              rd_valid_q;
    logic [DQ_W-1:0]   rd_data_q;

    // Timer controls.
    logic          ld_gap, ld_ras, ld_rc, ld_wr;
    logic [CW-1:0] gap_val;
    logic          gap_z, ras_z, rc_z, wr_z;
    logic          ref_due, ref_ack, accept, hit;

    // Generic gap timer: next command of any kind.
    sdr_down_ctr #(.W(CW)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(ld_gap), .load_val(gap_val), .zero(gap_z));
    // Active-time timer: activate to precharge.
    sdr_down_ctr #(.W(CW)) u_ras (
        .clk(clk), .rst_n(rst_n), .load(ld_ras), .load_val(CW'(T_RAS - 1)), .zero(ras_z));
    // Row-cycle timer: activate/refresh to next activate/refresh.
    sdr_down_ctr #(.W(CW)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(ld_rc), .load_val(CW'(T_RC - 1)), .zero(rc_z));
    // Write-recovery timer: write to precharge.
    sdr_down_ctr #(.W(CW)) u_wr (
        .clk(clk), .rst_n(rst_n), .load(ld_wr), .load_val(CW'(T_WR - 1)), .zero(wr_z));

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack), .due(ref_due));

    assign init_done = (st_q == ST_IDLE) || (st_q == ST_RDWAIT);
    assign hit       = row_open_q && (open_bank_q == req_bank) && (open_row_q == req_row);

    // Purpose: choose the next command, timer loads and state.
    always_comb begin
        st_d        = st_q;
        iref_d      = iref_q;
        row_open_d  = row_open_q;
        open_bank_d = open_bank_q;
        open_row_d  = open_row_q;
        cmd_d       = CMD_NOP;
        ba_d        = '0;
        ma_d        = '0;
        dqm_d       = '0;
        dq_oe_d     = 1'b0;
        dq_out_d    = '0;
        ld_gap      = 1'b0;
        gap_val     = '0;
        ld_ras      = 1'b0;
        ld_rc       = 1'b0;
        ld_wr       = 1'b0;
        ref_ack     = 1'b0;
        accept      = 1'b0;
        unique case (st_q)
            ST_BOOT: begin
                ld_gap  = 1'b1;
                gap_val = CW'(INIT_WAIT - 1);
                st_d    = ST_PWR;
            end
            ST_PWR: begin
                if (gap_z) begin
                    cmd_d        = CMD_PRE;
                    ma_d[AP_BIT] = 1'b1;
                    ld_gap       = 1'b1;
                    gap_val      = CW'(T_RP - 1);
                    iref_d       = 1'b0;
                    st_d         = ST_IREF;
                end
            end
            ST_IREF: begin
                if (gap_z) begin
                    cmd_d   = CMD_REF;
                    ld_gap  = 1'b1;
                    gap_val = CW'(T_RC - 1);
                    iref_d  = 1'b1;
                    if (iref_q) begin
                        st_d = ST_IMRS;
                    end
                end
            end
            ST_IMRS: begin
                if (gap_z) begin
                    cmd_d   = CMD_MRS;
                    ma_d    = MODE_WORD;
                    ld_gap  = 1'b1;
                    gap_val = CW'(T_MRD - 1);
                    st_d    = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                if (gap_z) begin
                    st_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (row_open_q && (ref_due || (req_valid && !hit))) begin
                    // Close the open row before a refresh or a row miss.
                    if (gap_z && ras_z && wr_z) begin
                        cmd_d      = CMD_PRE;
                        ba_d       = open_bank_q;
                        ld_gap     = 1'b1;
                        gap_val    = CW'(T_RP - 1);
                        row_open_d = 1'b0;
                    end
                end else if (ref_due) begin
                    if (gap_z && rc_z) begin
                        cmd_d   = CMD_REF;
                        ld_gap  = 1'b1;
                        gap_val = CW'(T_RC - 1);
                        ld_rc   = 1'b1;
                        ref_ack = 1'b1;
                    end
                end else if (req_valid && hit) begin
                    if (gap_z) begin
                        accept = 1'b1;
                        ba_d   = req_bank;
                        ma_d   = MA_W'(req_col);
                        if (req_we) begin
                            cmd_d    = CMD_WR;
                            dqm_d    = ~req_wmask;
                            dq_oe_d  = 1'b1;
                            dq_out_d = req_wdata;
                            ld_wr    = 1'b1;
                        end else begin
                            cmd_d = CMD_RD;
                            st_d  = ST_RDWAIT;
                        end
                    end
                end else if (req_valid) begin
                    if (gap_z && rc_z) begin
                        cmd_d       = CMD_ACT;
                        ba_d        = req_bank;
                        ma_d        = MA_W'(req_row);
                        ld_gap      = 1'b1;
                        gap_val     = CW'(T_RCD - 1);
                        ld_ras      = 1'b1;
                        ld_rc       = 1'b1;
                        row_open_d  = 1'b1;
                        open_bank_d = req_bank;
                        open_row_d  = req_row;
                    end
                end
            end
            ST_RDWAIT: begin
                if (rd_pipe_q[CAS_LAT]) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_BOOT;
        endcase
    end

    // Purpose: state, open-row and registered pin updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_BOOT;
            iref_q      <= 1'b0;
            row_open_q  <= 1'b0;
            open_bank_q <= '0;
            open_row_q  <= '0;
            cmd_q       <= CMD_NOP;
            cke_q       <= 1'b0;
            ba_q        <= '0;
            ma_q        <= '0;
            dqm_q       <= '0;
            dq_oe_q     <= 1'b0;
            dq_out_q    <= '0;
        end else begin
            st_q        <= st_d;
            iref_q      <= iref_d;
            row_open_q  <= row_open_d;
            open_bank_q <= open_bank_d;
            open_row_q  <= open_row_d;
            cmd_q       <= cmd_d;
            cke_q       <= 1'b1;
            ba_q        <= ba_d;
            ma_q        <= ma_d;
            dqm_q       <= dqm_d;
            dq_oe_q     <= dq_oe_d;
            dq_out_q    <= dq_out_d;
        end
    end

    // Purpose: track a read through the CAS latency and capture its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe_q  <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_pipe_q  <= {rd_pipe_q[CAS_LAT-1:0], accept && !req_we};
            rd_valid_q <= rd_pipe_q[CAS_LAT];
            if (rd_pipe_q[CAS_LAT]) begin
                rd_data_q <= mem_dq;
            end
        end
    end

    assign req_ready = accept;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign mem_cke   = cke_q;
    assign mem_cs_n  = cmd_q[3];
    assign mem_ras_n = cmd_q[2];
    assign mem_cas_n = cmd_q[1];
    assign mem_we_n  = cmd_q[0];
    assign mem_ba    = ba_q;
    assign mem_addr  = ma_q;
    assign mem_dqm   = dqm_q;
    assign mem_dq    = dq_oe_q ? dq_out_q : {DQ_W{1'bz}};

    // Checker counters: cycles since the pins last showed an activate / write.
    logic [CW-1:0] since_act_q, since_wr_q;

    // Purpose: saturating age counters observed from the command pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act_q <= '1;
            since_wr_q  <= '1;
        end else begin
            since_act_q <= (cmd_q == CMD_ACT) ? CW'(1) :
                           ((since_act_q == '1) ? since_act_q : since_act_q + 1'b1);
            since_wr_q  <= (cmd_q == CMD_WR) ? CW'(1) :
                           ((since_wr_q == '1) ? since_wr_q : since_wr_q + 1'b1);
        end
    end

    // R4: column command not earlier than T_RCD after its activate.
    a_r4_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) |-> (since_act_q >= CW'(T_RCD)));

    // R5: single-bank precharge respects active time and write recovery.
    a_r5_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q == CMD_PRE) && !mem_addr[AP_BIT]) |->
            ((since_act_q >= CW'(T_RAS)) && (since_wr_q >= CW'(T_WR))));

    // R6: refresh only with every bank closed.
    a_r6_ref_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> !row_open_q);

    // R1: no request is accepted before initialisation completes.
    a_r1_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);

    // R8: the data bus is driven only with a write command.
    a_r8_dq_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_q |-> (cmd_q == CMD_WR));

    // R9: read data strobes only right after waiting on a read.
    a_r9_valid_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_q) |-> (st_q == ST_IDLE));

endmodule

// File: tb/sdr_cmd_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: a cycle-accurate SDRAM model checks command legality and spacing;
// a host driver mixes directed and random accesses against a shadow memory.
module sdr_cmd_ctrl_tb;

    localparam int CL    = 3;
    localparam int IW    = 50;
    localparam int RI    = 200;
    localparam int TRCD  = 3;
    localparam int TRP   = 3;
    localparam int TRAS  = 7;
    localparam int TRC   = 10;
    localparam int TMRD  = 2;
    localparam int TWR   = 2;
    localparam int SLACK = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done, req_ready, rd_valid;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0, rd_data;
    logic [3:0]  req_wmask = '0;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] ma;
    logic [3:0]  dqm;
    wire  [31:0] dq;

    logic        drv_en = 1'b0;
    logic [31:0] drv_data = '0;
    assign dq = drv_en ? drv_data : 32'hzzzz_zzzz;

    always #4 clk = ~clk;

    sdr_cmd_ctrl #(
        .CAS_LAT(CL), .INIT_WAIT(IW), .REF_INTERVAL(RI), .T_RCD(TRCD), .T_RP(TRP),
        .T_RAS(TRAS), .T_RC(TRC), .T_MRD(TMRD), .T_WR(TWR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_valid(req_valid),
        .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_wmask(req_wmask), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n),
        .mem_cas_n(cas_n), .mem_we_n(we_n), .mem_ba(ba), .mem_addr(ma),
        .mem_dqm(dqm), .mem_dq(dq)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int midx(input logic [1:0] b, input logic [10:0] r, input logic [7:0] c);
        return int'({b, r[4:0], c[4:0]});
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] en);
        logic [31:0] res = old;
        for (int b = 0; b < 4; b++) if (en[b]) res[b*8 +: 8] = nw[b*8 +: 8];
        return res;
    endfunction

    // ---------------- memory model ----------------
    logic [31:0] mem    [0:4095];
    logic [31:0] shadow [0:4095];
    int cyc = 0, last_act = -1000, last_pre = -1000, last_ref = -1000;
    int last_mrs = -1000, last_wr = -1000, last_rt_ref = -1, init_step = 0;
    int n_act = 0, n_pre = 0, n_ref = 0, n_rt_ref = 0, init_end_cyc = 0;
    bit row_open_m = 0;
    logic [1:0]  ob = '0;
    logic [10:0] orow = '0;
    int rd_cd = 0;
    logic [31:0] rd_word = '0;

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            cyc++;
            c = {cs_n, ras_n, cas_n, we_n};
            if (rd_cd == 1) begin
                drv_en <= 1'b1;
                drv_data <= rd_word;
                rd_cd <= 0;
            end else begin
                drv_en <= 1'b0;
                if (rd_cd > 1) rd_cd <= rd_cd - 1;
            end
            if (c != 4'b0111 && !c[3]) begin
                chk(cyc - last_mrs >= TMRD, "R1", "gap after mode set", cyc - last_mrs, TMRD);
            end
            case (c)
                4'b0010: begin
                    if (init_step == 0) begin
                        chk(ma[10] == 1'b1, "R1", "init precharge-all A10", ma[10], 1);
                        chk(cyc > IW, "R1", "init wait length", cyc, IW);
                        init_step = 1;
                    end else begin
                        chk(row_open_m, "R7", "precharge with a row open", row_open_m, 1);
                        chk(ma[10] == 1'b0 && ba == ob, "R7", "single-bank precharge of open bank", ba, ob);
                        chk(cyc - last_act >= TRAS, "R5", "active time", cyc - last_act, TRAS);
                        chk(cyc - last_wr >= TWR, "R5", "write recovery", cyc - last_wr, TWR);
                    end
                    row_open_m = 0;
                    last_pre = cyc;
                    n_pre++;
                end
                4'b0001: begin
                    chk(!row_open_m, "R6", "refresh with banks closed", row_open_m, 0);
                    chk(cyc - last_pre >= TRP, "R6", "precharge to refresh", cyc - last_pre, TRP);
                    chk(cyc - last_ref >= TRC, "R6", "refresh to refresh", cyc - last_ref, TRC);
                    if (init_step == 1 || init_step == 2) begin
                        init_step++;
                    end else begin
                        chk(init_step == 4, "R1", "refresh order", init_step, 4);
                        if (last_rt_ref >= 0)
                            chk(cyc - last_rt_ref <= RI + SLACK, "R6", "refresh interval",
                                cyc - last_rt_ref, RI + SLACK);
                        last_rt_ref = cyc;
                        n_rt_ref++;
                    end
                    last_ref = cyc;
                    n_ref++;
                end
                4'b0000: begin
                    chk(init_step == 3, "R1", "mode set after two refreshes", init_step, 3);
                    chk(ma == 12'h030, "R3", "mode word", ma, 12'h030);
                    chk(ba == 2'b00, "R3", "mode set bank", ba, 0);
                    init_step = 4;
                    last_mrs = cyc;
                end
                4'b0011: begin
                    chk(init_step == 4, "R1", "activate after init", init_step, 4);
                    chk(!row_open_m, "R5", "activate with no row open", row_open_m, 0);
                    chk(cyc - last_pre >= TRP, "R5", "precharge to activate", cyc - last_pre, TRP);
                    chk(cyc - last_act >= TRC, "R5", "activate to activate", cyc - last_act, TRC);
                    chk(cyc - last_ref >= TRC, "R5", "refresh to activate", cyc - last_ref, TRC);
                    chk(ma[11] == 1'b0, "R4", "activate A11", ma[11], 0);
                    row_open_m = 1;
                    ob = ba;
                    orow = ma[10:0];
                    last_act = cyc;
                    n_act++;
                end
                4'b0101, 4'b0100: begin
                    int ix;
                    chk(row_open_m && ba == ob, "R4", "column command to open bank", ba, ob);
                    chk(cyc - last_act >= TRCD, "R4", "activate to column", cyc - last_act, TRCD);
                    chk(ma[11:8] == 4'h0, "R4", "column A11..A8 (no auto-precharge)", ma[11:8], 0);
                    ix = midx(ba, orow, ma[7:0]);
                    if (c == 4'b0100) begin
                        for (int b = 0; b < 4; b++)
                            if (!dqm[b]) mem[ix][b*8 +: 8] = dq[b*8 +: 8];
                        last_wr = cyc;
                    end else begin
                        rd_cd <= CL - 1;
                        rd_word <= mem[ix];
                    end
                end
                default: begin
                    if (!c[3] && c != 4'b0111)
                        chk(1'b0, "R2", "illegal command encoding", c, 4'b0111);
                end
            endcase
        end
    end

    // ---------------- host driver ----------------
    task automatic host_op(input bit we, input logic [1:0] b, input logic [10:0] r,
                           input logic [7:0] c, input logic [31:0] d, input logic [3:0] m);
        bit got = 0;
        int ix = midx(b, r, c);
        @(negedge clk);
        req_valid = 1'b1;
        req_we = we;
        req_addr = {b, r, c};
        req_wdata = d;
        req_wmask = m;
        while (!got) begin
            if (req_ready) got = 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (we) begin
            shadow[ix] = merge(shadow[ix], d, m);
        end else begin
            while (!rd_valid) @(negedge clk);
            chk(rd_data == shadow[ix], "R9", "read data (R8 masked merge)", rd_data, shadow[ix]);
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a0, p0, r0;
        bit early;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state (R1, R2, R9).
        chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "NOP in reset",
            {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(!init_done && !req_ready, "R1", "not ready in reset", init_done, 0);
        chk(!rd_valid, "R9", "rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        // Hold a request during init; it must not be accepted (R1).
        req_valid = 1'b1;
        req_we = 1'b0;
        req_addr = '0;
        early = 0;
        @(negedge clk);
        chk(cke == 1'b1, "R1", "cke after reset", cke, 1);
        while (!init_done) begin
            if (req_ready) early = 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(!early, "R1", "request accepted before init_done", early, 0);
        chk(init_step == 4, "R1", "init sequence complete", init_step, 4);
        chk(cyc >= IW + TRP + 2 * TRC + TMRD, "R1", "init length", cyc, IW + TRP + 2 * TRC + TMRD);
        init_end_cyc = cyc;

        // Full write then read back, then a partial mask (R8, R9).
        host_op(1, 2'd1, 11'd2, 8'd5, 32'hA1B2_C3D4, 4'hF);
        host_op(0, 2'd1, 11'd2, 8'd5, 32'h0, 4'h0);
        host_op(1, 2'd1, 11'd2, 8'd5, 32'h1122_3344, 4'b0101);
        host_op(0, 2'd1, 11'd2, 8'd5, 32'h0, 4'h0);
        host_op(1, 2'd1, 11'd2, 8'd6, 32'hFFFF_FFFF, 4'b1000);
        host_op(0, 2'd1, 11'd2, 8'd6, 32'h0, 4'h0);

        // Row hit: no new activate unless a refresh closed the row (R7).
        a0 = n_act;
        r0 = n_ref;
        host_op(0, 2'd1, 11'd2, 8'd7, 32'h0, 4'h0);
        chk(n_act - a0 == ((n_ref != r0) ? 1 : 0), "R7", "activates on row hit",
            n_act - a0, (n_ref != r0) ? 1 : 0);

        // Row miss, same bank: precharge then one activate (R7).
        a0 = n_act;
        p0 = n_pre;
        host_op(1, 2'd1, 11'd3, 8'd7, 32'hDEAD_BEEF, 4'hF);
        chk(n_act - a0 == 1, "R7", "activates on row miss", n_act - a0, 1);
        chk(n_pre - p0 >= 1, "R7", "precharge on row miss", n_pre - p0, 1);

        // Bank miss (R7).
        a0 = n_act;
        host_op(0, 2'd3, 11'd3, 8'd7, 32'h0, 4'h0);
        chk(n_act - a0 == 1, "R7", "activates on bank miss", n_act - a0, 1);

        // Idle with a row open: refreshes must keep coming (R6, R10).
        r0 = n_rt_ref;
        repeat (2 * RI + SLACK) @(negedge clk);
        chk(n_rt_ref - r0 >= 2, "R10", "refreshes while idle", n_rt_ref - r0, 2);

        // Random traffic over a small address pool.
        for (int k = 0; k < 500; k++) begin
            logic [1:0] b;
            logic [10:0] r;
            logic [7:0] c;
            logic [3:0] m;
            b = 2'($urandom % 4);
            r = 11'($urandom % 3);
            c = 8'($urandom % 32);
            m = 4'($urandom % 16);
            if (m == 4'h0) m = 4'hF;
            host_op(($urandom % 2) == 1, b, r, c, $urandom, m);
        end

        // Refresh count over the whole run (R10).
        chk(n_rt_ref >= (cyc - init_end_cyc) / RI - 1, "R10", "run-time refresh count",
            n_rt_ref, (cyc - init_end_cyc) / RI - 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule